// File: doc/BRIEF.md
# MDIO Management Master

This block is a register-programmed master for the two-wire PHY management bus. It builds complete management frames and shifts them out on MDIO, timed by an MDC clock that it divides down from the system clock. On reads it releases the line and samples the PHY's answer. One register interface serves both the direct-register framing (Clause 22) and the indirect extended framing (Clause 45). A mode bit chooses which framing the next frame uses.

Software programs the divider and the mode, then writes the PHY port and the device (or register) number into the control register. Each frame is launched by one register write. Writing the data register sends a write frame. Setting the read bit in the control register sends a read frame. In extended mode, writing the address register sends an address frame. Two busy flags and a read-error flag let software poll for completion. Software treats a failed read as all ones.

Top module: `mdio_master`

## Requirements
- R1: After reset, all four registers (configuration 0, control 1, address 2, data 3, selected by `reg_addr_i`) read as zero, MDC is low and MDIO is not driven.
- R2: With the configuration mode bit (bit 2) clear, frames are 32 ones, start 01, opcode 01 (write) or 10 (read), 5-bit port, 5-bit register number, turnaround 10, then 16 data bits, all MSB first.
- R3: With the mode bit set, frames use start 00 and opcode 00 (address), 01 (write) or 11 (read). A write to the address register launches an address frame carrying its 16 bits, only in this mode. In the other mode that write changes nothing and sends no frame.
- R4: Control register fields are device/register number [4:0] and port [9:5]. Writing bit 15 as 1 launches a read frame, and bit 15 reads back as 0. Writing the data register's bits [15:0] launches a write frame and holds that value.
- R5: MDC toggles every N system clocks, where N is the divider in configuration bits [24:16]. With N zero, MDC stays low and a pending frame waits until N is made non-zero.
- R6: Configuration bit 0 (busy) is set for every frame. Data register bit 31 (data busy) is set only for read and write frames. Both clear one system clock after the MDC rising edge that carries the last frame bit.
- R7: During a read frame, MDIO is released for both turnaround bits and the data bits. The 16 bits sampled on MDC rising edges are held in data register bits [15:0].
- R8: If MDIO is high at the second turnaround bit of a read, configuration bit 1 (read error) is set. The flag clears when the next frame starts.
- R9: Writes to the control, address and data registers while busy is set are ignored.
- R10: MDC stays low while no frame is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data of the selected register |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe_o | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
Two situations are hard to reach from the ports: register writes that collide with a frame already in flight, and a frame left pending while the divider is zero. The bench gets to the first by issuing control, data and address writes on the clock cycles right after a launch, while busy is known to be set. It then compares the whole 64-bit frame captured on the line, and the register readbacks, with the values from the first writes. For the second it launches a write with the divider cleared, holds for many clocks to show that MDC never moves, then programs a divider in mid-frame and checks that the frame completes intact. A responder in the bench drives the turnaround and data bits, or leaves the line pulled high to provoke the read error.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_BITS = 64;
  localparam int TA_FIRST   = 46;
  localparam int TA_LAST    = 47;
  localparam int DATA_FIRST = 48;

  localparam logic [1:0] REG_CFG  = 2'd0;
  localparam logic [1:0] REG_CTRL = 2'd1;
  localparam logic [1:0] REG_ADDR = 2'd2;
  localparam logic [1:0] REG_DATA = 2'd3;

  localparam int CFG_BUSY    = 0;
  localparam int CFG_RDERR   = 1;
  localparam int CFG_MODE    = 2;
  localparam int CFG_DIV_LSB = 16;
  localparam int CTRL_RD     = 15;
  localparam int DATA_BUSY   = 31;

  typedef enum logic [1:0] {FK_ADDR = 2'd0, FK_WRITE = 2'd1, FK_READ = 2'd2} frame_kind_e;

  function automatic logic [FRAME_BITS-1:0] build_frame(input logic c45, input frame_kind_e kind,
                                                        input logic [4:0] port, input logic [4:0] dev,
                                                        input logic [15:0] data);
    logic [1:0] st, op;
    st = c45 ? 2'b00 : 2'b01;
    case (kind)
      FK_ADDR:  op = 2'b00;
      FK_WRITE: op = 2'b01;
      default:  op = c45 ? 2'b11 : 2'b10;
    endcase
    return {32'hFFFF_FFFF, st, op, port, dev, 2'b10, data};
  endfunction
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
  parameter int DIV_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             mdc_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             mdc_q, run, term;

  assign run    = en_i && (div_i != '0);
  // >= keeps a shrinking divider from stranding the counter
  assign term   = run && (cnt_q >= div_i - DIV_W'(1));
  assign rise_o = term && !mdc_q;
  assign fall_o = term && mdc_q;
  assign mdc_o  = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (term) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
    end
  end
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
  import mdio_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [FRAME_BITS-1:0] frame_i,
  input  logic                  rd_i,
  input  logic                  rise_i,
  input  logic                  fall_i,
  input  logic                  mdio_i,
  output logic                  busy_o,
  output logic                  done_o,
  output logic                  mdio_o,
  output logic                  oe_o,
  output logic                  ta_hi_o,
  output logic [15:0]           rx_o
);
  localparam int CW = $clog2(FRAME_BITS);

  logic [FRAME_BITS-1:0] tx_q;
  logic [CW-1:0]         cnt_q;
  logic [15:0]           rx_q;
  logic                  busy_q, fin_q, rd_q, ta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q   <= '0;
      cnt_q  <= '0;
      rx_q   <= '0;
      busy_q <= 1'b0;
      fin_q  <= 1'b0;
      rd_q   <= 1'b0;
      ta_q   <= 1'b0;
    end else if (fin_q) begin
      busy_q <= 1'b0;
      fin_q  <= 1'b0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        tx_q   <= frame_i;
        cnt_q  <= '0;
        rd_q   <= rd_i;
      end
    end else begin
      if (rise_i) begin
        if (cnt_q == CW'(TA_LAST))    ta_q <= mdio_i;
        if (cnt_q >= CW'(DATA_FIRST)) rx_q <= {rx_q[14:0], mdio_i};
        if (cnt_q == CW'(FRAME_BITS - 1)) fin_q <= 1'b1;
      end
      if (fall_i) begin
        tx_q  <= {tx_q[FRAME_BITS-2:0], 1'b0};
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  assign busy_o  = busy_q;
  assign done_o  = fin_q;
  assign mdio_o  = tx_q[FRAME_BITS-1];
  assign oe_o    = busy_q && !(rd_q && cnt_q >= CW'(TA_FIRST));
  assign ta_hi_o = ta_q;
  assign rx_o    = rx_q;
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_W = 9
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_wr_i,
  input  logic [1:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i
);
  logic             r_mode, r_data_busy, r_rd_err, r_rd_frame;
  logic [DIV_W-1:0] r_div;
  logic [4:0]       r_port, r_dev;
  logic [15:0]      r_addr, r_data;

  logic             eng_busy, eng_done, eng_ta_hi, mdc_rise, mdc_fall;
  logic [15:0]      eng_rx;
  logic             wr_idle, go_rd, go_adr, go_wr, start;
  logic [4:0]       port_n, dev_n;
  frame_kind_e      kind;
  logic [FRAME_BITS-1:0] frame;
  logic             unused_wdata;

  assign unused_wdata = ^reg_wdata_i;

  assign wr_idle = reg_wr_i && !eng_busy;
  assign go_rd   = wr_idle && (reg_addr_i == REG_CTRL) && reg_wdata_i[CTRL_RD];
  assign go_adr  = wr_idle && (reg_addr_i == REG_ADDR) && r_mode;
  assign go_wr   = wr_idle && (reg_addr_i == REG_DATA);
  assign start   = go_rd || go_adr || go_wr;
  assign port_n  = go_rd ? reg_wdata_i[9:5] : r_port;
  assign dev_n   = go_rd ? reg_wdata_i[4:0] : r_dev;
  assign kind    = go_rd ? FK_READ : (go_adr ? FK_ADDR : FK_WRITE);
  assign frame   = build_frame(r_mode, kind, port_n, dev_n, reg_wdata_i[15:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r_mode      <= 1'b0;
      r_div       <= '0;
      r_port      <= '0;
      r_dev       <= '0;
      r_addr      <= '0;
      r_data      <= '0;
      r_data_busy <= 1'b0;
      r_rd_err    <= 1'b0;
      r_rd_frame  <= 1'b0;
    end else begin
      // configuration stays writable mid-frame so a zero divider can be repaired
      if (reg_wr_i && reg_addr_i == REG_CFG) begin
        r_mode <= reg_wdata_i[CFG_MODE];
        r_div  <= reg_wdata_i[CFG_DIV_LSB +: DIV_W];
      end
      if (wr_idle && reg_addr_i == REG_CTRL) begin
        r_port <= reg_wdata_i[9:5];
        r_dev  <= reg_wdata_i[4:0];
      end
      if (go_adr) r_addr <= reg_wdata_i[15:0];
      if (go_wr)  r_data <= reg_wdata_i[15:0];
      if (start) begin
        r_rd_err    <= 1'b0;
        r_data_busy <= !go_adr;
        r_rd_frame  <= go_rd;
      end else if (eng_done) begin
        r_data_busy <= 1'b0;
        if (r_rd_frame) begin
          r_rd_err <= eng_ta_hi;
          r_data   <= eng_rx;
        end
      end
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      REG_CFG: begin
        reg_rdata_o[CFG_BUSY]                   = eng_busy;
        reg_rdata_o[CFG_RDERR]                  = r_rd_err;
        reg_rdata_o[CFG_MODE]                   = r_mode;
        reg_rdata_o[CFG_DIV_LSB +: DIV_W]       = r_div;
      end
      REG_CTRL: reg_rdata_o[9:0] = {r_port, r_dev};
      REG_ADDR: reg_rdata_o[15:0] = r_addr;
      default: begin
        reg_rdata_o[15:0]      = r_data;
        reg_rdata_o[DATA_BUSY] = r_data_busy;
      end
    endcase
  end

  mdio_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (eng_busy),
    .div_i  (r_div),
    .mdc_o  (mdc_o),
    .rise_o (mdc_rise),
    .fall_o (mdc_fall)
  );

  mdio_frame_eng u_eng (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .frame_i (frame),
    .rd_i    (go_rd),
    .rise_i  (mdc_rise),
    .fall_i  (mdc_fall),
    .mdio_i  (mdio_i),
    .busy_o  (eng_busy),
    .done_o  (eng_done),
    .mdio_o  (mdio_o),
    .oe_o    (mdio_oe_o),
    .ta_hi_o (eng_ta_hi),
    .rx_o    (eng_rx)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
  parameter int DIV_W = 9
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mdc_o,
  input logic             busy,
  input logic             data_busy,
  input logic             rd_err,
  input logic             rd_frame,
  input logic             reg_wr_i,
  input logic [1:0]       reg_addr_i,
  input logic [DIV_W-1:0] div,
  input logic [4:0]       port,
  input logic [4:0]       dev
);
  AST_MDC_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |=> !mdc_o); // R10

  AST_DIV_ZERO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div == '0 && !mdc_o) |=> !mdc_o); // R5

  AST_DATA_BUSY_SUBSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_busy |-> busy); // R6

  AST_RDERR_FROM_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_err) |-> rd_frame); // R8

  AST_CTRL_HELD_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && reg_wr_i && reg_addr_i == 2'd1) |=> ($stable(port) && $stable(dev))); // R9
endmodule

bind mdio_master mdio_master_chk #(.DIV_W(DIV_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mdc_o      (mdc_o),
  .busy       (eng_busy),
  .data_busy  (r_data_busy),
  .rd_err     (r_rd_err),
  .rd_frame   (r_rd_frame),
  .reg_wr_i   (reg_wr_i),
  .reg_addr_i (reg_addr_i),
  .div        (r_div),
  .port       (r_port),
  .dev        (r_dev)
);

// File: tb/tb_mdio_master.sv
module tb_mdio_master;
  localparam int CLK_P = 10;
  localparam int DIV   = 3;
  localparam int NVEC  = 6;
  // {c45, kind(0 write,1 read,2 addr), port, dev, data}
  localparam logic [28:0] VEC [NVEC] = '{
    {1'b0, 2'd0, 5'd1,  5'd2,  16'hA5C3},
    {1'b0, 2'd1, 5'd31, 5'd16, 16'h1234},
    {1'b1, 2'd2, 5'd3,  5'd1,  16'h8001},
    {1'b1, 2'd0, 5'd3,  5'd1,  16'hFFFF},
    {1'b1, 2'd1, 5'd21, 5'd30, 16'h0000},
    {1'b0, 2'd0, 5'd0,  5'd0,  16'h0000}
  };

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0, rdata;
  logic        mdc, mdo, moe, line;
  int          n_chk = 0, n_fail = 0;
  int          rise_cnt = 0;
  logic [63:0] cap = '0;
  logic        phy_en = 1'b0;
  logic [15:0] phy_val = '0;
  logic        oe_ta0 = 1'b1, oe_ta1 = 1'b1;
  time         t_prev = 0, t_last = 0;

  always #(CLK_P/2) clk = ~clk;

  always_comb begin
    if (moe) line = mdo;
    else if (phy_en && rise_cnt == 47) line = 1'b0;
    else if (phy_en && rise_cnt >= 48 && rise_cnt <= 63) line = phy_val[4'(63 - rise_cnt)];
    else line = 1'b1;
  end

  always @(posedge mdc) begin
    cap = {cap[62:0], line};
    if (rise_cnt == 46) oe_ta0 = moe;
    if (rise_cnt == 47) oe_ta1 = moe;
    t_prev = t_last;
    t_last = $time;
    rise_cnt++;
  end

  mdio_master dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .mdc_o(mdc), .mdio_o(mdo), .mdio_oe_o(moe), .mdio_i(line)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    int k = 0;
    do begin
      @(negedge clk); rd_reg(2'd0, v); k++;
    end while (v[0] && k < 5000);
  endtask

  function automatic logic [31:0] cfg_w(input logic c45, input logic [8:0] dv);
    return {7'b0, dv, 13'b0, c45, 2'b0};
  endfunction

  function automatic logic [31:0] ctrl_w(input logic rd, input logic [4:0] p, input logic [4:0] d);
    return {16'b0, rd, 5'b0, p, d};
  endfunction

  function automatic logic [63:0] exp_frame(input logic c45, input int kind, input logic [4:0] p,
                                            input logic [4:0] d, input logic [15:0] data);
    logic [1:0] st, op;
    st = c45 ? 2'b00 : 2'b01;
    if (kind == 0) op = 2'b01;
    else if (kind == 2) op = 2'b00;
    else op = c45 ? 2'b11 : 2'b10;
    return {32'hFFFF_FFFF, st, op, p, d, 2'b10, data};
  endfunction

  initial begin : watchdog
    #(CLK_P * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd_reg(2'(a), v);
      check(v == 32'h0, "R1 register reset", 64'(v), 64'h0);
    end
    check(!mdc && !moe, "R1 mdc/oe reset", {62'b0, mdc, moe}, 64'h0);

    // table of frames
    for (int i = 0; i < NVEC; i++) begin
      logic c45; int kind; logic [4:0] p, d; logic [15:0] dat;
      c45 = VEC[i][28]; kind = int'(VEC[i][27:26]);
      p = VEC[i][25:21]; d = VEC[i][20:16]; dat = VEC[i][15:0];
      wr_reg(2'd0, cfg_w(c45, 9'(DIV)));
      rise_cnt = 0;
      phy_en = (kind == 1);
      phy_val = dat;
      if (kind == 0) begin
        wr_reg(2'd1, ctrl_w(1'b0, p, d));
        wr_reg(2'd3, {16'h0, dat});           // R4 data write launches frame
      end else if (kind == 1) begin
        wr_reg(2'd1, ctrl_w(1'b1, p, d));     // R4 read bit launches frame
      end else begin
        wr_reg(2'd1, ctrl_w(1'b0, p, d));
        wr_reg(2'd2, {16'h0, dat});           // R3 address frame
      end
      rd_reg(2'd0, v);
      check(v[0] == 1'b1, "R6 status busy set", 64'(v[0]), 64'h1);
      rd_reg(2'd3, v);
      check(v[31] == (kind != 2), "R6 data busy only for data frames", 64'(v[31]), 64'(kind != 2));
      wait_idle();
      if (c45) check(cap == exp_frame(c45, kind, p, d, dat), "R3 extended frame bits", cap, exp_frame(c45, kind, p, d, dat));
      else     check(cap == exp_frame(c45, kind, p, d, dat), "R2 direct frame bits", cap, exp_frame(c45, kind, p, d, dat));
      check(rise_cnt == 64, "R2 one frame of 64 bits", 64'(rise_cnt), 64'd64);
      rd_reg(2'd3, v);
      if (kind == 1) begin
        check(v[15:0] == dat, "R7 read data held", 64'(v[15:0]), 64'(dat));
        check(!oe_ta0 && !oe_ta1, "R7 line released at turnaround", {62'b0, oe_ta0, oe_ta1}, 64'h0);
        rd_reg(2'd0, v);
        check(v[1] == 1'b0, "R8 no read error with responder", 64'(v[1]), 64'h0);
      end else if (kind == 0) begin
        check(v[15:0] == dat, "R4 data register holds written value", 64'(v[15:0]), 64'(dat));
      end
      rd_reg(2'd1, v);
      check(v == ctrl_w(1'b0, p, d), "R4 control readback, read bit zero", 64'(v), 64'(ctrl_w(1'b0, p, d)));
    end
    check(t_last - t_prev == time'(2 * DIV * CLK_P), "R5 mdc period", 64'(t_last - t_prev), 64'(2 * DIV * CLK_P));

    // R6 busy clears one clock after last rising edge
    rise_cnt = 0; phy_en = 1'b0;
    wr_reg(2'd3, 32'h0000_0F0F);
    wait (rise_cnt == 64);
    @(negedge clk); rd_reg(2'd0, v);
    check(v[0] == 1'b1, "R6 busy in final cycle", 64'(v[0]), 64'h1);
    @(negedge clk); rd_reg(2'd0, v);
    check(v[0] == 1'b0, "R6 busy cleared after one clock", 64'(v[0]), 64'h0);
    rd_reg(2'd3, v);
    check(v[31] == 1'b0, "R6 data busy cleared", 64'(v[31]), 64'h0);
    repeat (10) @(negedge clk);
    check(!mdc && !moe && rise_cnt == 64, "R10 mdc idle low", {62'b0, mdc, moe}, 64'h0);

    // R8 read error when nothing answers
    rise_cnt = 0; phy_en = 1'b0;
    wr_reg(2'd1, ctrl_w(1'b1, 5'd5, 5'd3));
    wait_idle();
    rd_reg(2'd0, v);
    check(v[1] == 1'b1, "R8 read error set", 64'(v[1]), 64'h1);
    rd_reg(2'd3, v);
    check(v[15:0] == 16'hFFFF, "R8 unanswered read gives ones", 64'(v[15:0]), 64'hFFFF);
    wr_reg(2'd3, 32'h0000_0001);
    rd_reg(2'd0, v);
    check(v[1] == 1'b0, "R8 read error cleared at start", 64'(v[1]), 64'h0);
    wait_idle();

    // R9 writes during busy ignored
    rise_cnt = 0;
    wr_reg(2'd1, ctrl_w(1'b0, 5'd7, 5'd9));
    wr_reg(2'd3, 32'h0000_1357);
    wr_reg(2'd1, ctrl_w(1'b1, 5'd2, 5'd4));
    wr_reg(2'd3, 32'h0000_FFFF);
    wr_reg(2'd2, 32'h0000_ABCD);
    wait_idle();
    repeat (20) @(negedge clk);
    rd_reg(2'd1, v);
    check(v == ctrl_w(1'b0, 5'd7, 5'd9), "R9 control unchanged", 64'(v), 64'(ctrl_w(1'b0, 5'd7, 5'd9)));
    rd_reg(2'd3, v);
    check(v[15:0] == 16'h1357, "R9 data unchanged", 64'(v[15:0]), 64'h1357);
    check(cap == exp_frame(1'b0, 0, 5'd7, 5'd9, 16'h1357), "R9 frame unchanged", cap, exp_frame(1'b0, 0, 5'd7, 5'd9, 16'h1357));
    check(rise_cnt == 64, "R9 no extra frame", 64'(rise_cnt), 64'd64);

    // R3 address write ignored in direct mode
    rise_cnt = 0;
    wr_reg(2'd2, 32'h0000_4444);
    rd_reg(2'd0, v);
    check(v[0] == 1'b0, "R3 no frame from address write", 64'(v[0]), 64'h0);
    repeat (40) @(negedge clk);
    check(rise_cnt == 0, "R3 no mdc from address write", 64'(rise_cnt), 64'h0);
    rd_reg(2'd2, v);
    check(v == 32'h0000_8001, "R3 address register unchanged", 64'(v), 64'h8001);

    // R5 zero divider stalls, then recovers
    wr_reg(2'd0, cfg_w(1'b0, 9'd0));
    rise_cnt = 0;
    wr_reg(2'd3, 32'h0000_2222);
    repeat (100) @(negedge clk);
    rd_reg(2'd0, v);
    check(v[0] == 1'b1 && rise_cnt == 0 && !mdc, "R5 zero divider holds mdc", {31'b0, v[0], 32'(rise_cnt)}, 64'h1_0000_0000);
    wr_reg(2'd0, cfg_w(1'b0, 9'(DIV)));
    wait_idle();
    check(cap == exp_frame(1'b0, 0, 5'd7, 5'd9, 16'h2222), "R5 frame after divider set", cap, exp_frame(1'b0, 0, 5'd7, 5'd9, 16'h2222));
    check(rise_cnt == 64, "R5 full frame after divider set", 64'(rise_cnt), 64'd64);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule